// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a direct-mapped array of line states and tags, one entry per line. Each line is Modified, Shared or Invalid. Processor reads and writes arrive on one side. The controller either completes them locally or raises a bus request. Once the arbiter grants the bus, it issues a read, a read-for-ownership or a write-back. On the other side, the controller watches transactions that other caches place on the bus. It downgrades or invalidates its own copy, and it flushes dirty data when a peer needs it.

The data path, main memory and the arbiter itself lie outside the block. A processor request is held stable until `cpu_done` pulses. A read port for the array (`look_idx`, `look_state`, `look_tag`) exposes the line state and tag of any index.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line reads Invalid. The line state encoding is 2'b00 Invalid, 2'b01 Shared and 2'b10 Modified. The bus command encoding is 2'b00 none, 2'b01 read, 2'b10 read-for-ownership and 2'b11 write-back. An address is {tag, index}, with the index in the low bits.
- R2: A processor read that misses a clean line requests the bus. On the granted cycle it issues command 01 with the request address and pulses `cpu_done`. The line then holds the new tag in state Shared.
- R3: A processor write to an Invalid line, a tag miss or a Shared line issues command 10 on the granted cycle and pulses `cpu_done`. The line then becomes Modified with the request tag.
- R4: A read that hits Shared or Modified, and a write that hits Modified, pulse `cpu_done` in the same cycle. They assert no bus request, and the line state is unchanged except that a write leaves Modified.
- R5: A snooped read that hits a Modified line asserts `flush_valid` with the snooped address in that cycle. The line becomes Shared.
- R6: A snooped read-for-ownership that hits a Modified line flushes, and the line becomes Invalid. One that hits a Shared line invalidates it without a flush.
- R7: A snooped read that hits a Shared line, any snooped write-back, and any snoop whose tag does not match leave the line unchanged and assert no flush.
- R8: A snoop whose requester ID equals the controller's own ID is ignored entirely.
- R9: A bus transaction is issued only in a cycle where `bus_gnt` is high. Without a grant, `bus_req` stays high and `cpu_done` stays low.
- R10: A miss on a line that is Modified under another tag first issues command 11 carrying the old tag's address. This empties the line to Invalid and does not pulse `cpu_done`. A later grant then fetches the new line.
- R11: A foreign snoop to the same index as a pending processor request takes priority for that cycle. In that cycle the request raises no bus request and no `cpu_done`, and the snoop's state change is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request pending |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_addr | input | TAG_W+IDX_W | Request address {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_issue | output | 1 | Own transaction on the bus this cycle |
| bus_cmd | output | 2 | Own bus command |
| bus_addr | output | TAG_W+IDX_W | Own bus address |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| flush_valid | output | 1 | Dirty data supplied for the snooped line |
| flush_addr | output | TAG_W+IDX_W | Address of the flushed line |
| look_idx | input | IDX_W | Array read index |
| look_state | output | 2 | State of line `look_idx` |
| look_tag | output | TAG_W | Tag of line `look_idx` |

## Verification
The assertions check several properties on every cycle. Transactions go out only under grant. A flush never follows a snoop carrying the controller's own ID, and a flushed line is no longer Modified on the next cycle. A completed write leaves its line Modified, and a write-back leaves its line Invalid. No line ever holds the unused state encoding. The bench scenarios cover the rest: the exact command, address and completion cycle of each transition, including stalls until grant. They also cover the two-step replacement of a dirty line, the silent cases in which nothing may change, and the snoop-over-processor priority at a shared index.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int NLINES = 8,
  parameter int TAG_W  = 4,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0,
  localparam int IDX_W  = $clog2(NLINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_issue,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  input  logic [IDX_W-1:0]  look_idx,
  output logic [1:0]        look_state,
  output logic [TAG_W-1:0]  look_tag
);
  localparam logic [1:0] INV = 2'b00, SHR = 2'b01, MOD = 2'b10;
  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_RDX = 2'b10, C_WB = 2'b11;

  logic [NLINES-1:0][1:0]       st;
  logic [NLINES-1:0][TAG_W-1:0] tg;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [1:0]       c_st, s_st;
  logic c_hit, s_on, s_hit, conflict, go, need_wb, local_ok;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign c_st  = st[c_idx];
  assign s_st  = st[s_idx];

  assign c_hit    = (c_st != INV) && (tg[c_idx] == c_tag);
  assign s_on     = snp_valid && (snp_id != MY_ID);
  assign s_hit    = s_on && (s_st != INV) && (tg[s_idx] == s_tag);
  assign conflict = s_on && (s_idx == c_idx);
  assign go       = cpu_req && !conflict;
  assign need_wb  = !c_hit && (c_st == MOD);
  assign local_ok = c_hit && (!cpu_we || c_st == MOD);

  assign bus_req   = go && !local_ok;
  assign bus_issue = bus_req && bus_gnt;
  assign bus_cmd   = !bus_req ? C_NONE : need_wb ? C_WB : cpu_we ? C_RDX : C_RD;
  assign bus_addr  = need_wb ? {tg[c_idx], c_idx} : cpu_addr;
  assign cpu_done  = go && (local_ok || (bus_issue && !need_wb));

  assign flush_valid = s_hit && (s_st == MOD) && (snp_cmd == C_RD || snp_cmd == C_RDX);
  assign flush_addr  = snp_addr;

  assign look_state = st[look_idx];
  assign look_tag   = tg[look_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
      tg <= '0;
    end else begin
      if (bus_issue && need_wb) begin
        st[c_idx] <= INV;
      end else if (cpu_done && cpu_we) begin
        st[c_idx] <= MOD;
        tg[c_idx] <= c_tag;
      end else if (cpu_done && !local_ok) begin
        st[c_idx] <= SHR;
        tg[c_idx] <= c_tag;
      end
      if (s_hit) begin
        if (snp_cmd == C_RD && s_st == MOD) st[s_idx] <= SHR;
        else if (snp_cmd == C_RDX)          st[s_idx] <= INV;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int NLINES = 8,
  parameter int TAG_W  = 4,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0,
  localparam int IDX_W  = $clog2(NLINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_done,
  input logic                   cpu_we,
  input logic [ADDR_W-1:0]      cpu_addr,
  input logic                   bus_issue,
  input logic                   bus_gnt,
  input logic [1:0]             bus_cmd,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   snp_valid,
  input logic [ADDR_W-1:0]      snp_addr,
  input logic [ID_W-1:0]        snp_id,
  input logic                   flush_valid,
  input logic [NLINES-1:0][1:0] st
);
  assert_issue_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_issue |-> bus_gnt);

  assert_own_id_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_id == MY_ID) |-> !flush_valid);

  assert_write_makes_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |=> st[$past(cpu_addr[IDX_W-1:0])] == 2'b10);

  assert_flush_leaves_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> st[$past(snp_addr[IDX_W-1:0])] != 2'b10);

  assert_wb_empties_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_issue && bus_cmd == 2'b11) |=> st[$past(bus_addr[IDX_W-1:0])] == 2'b00);

  for (genvar i = 0; i < NLINES; i++) begin : g_legal
    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      st[i] != 2'b11);
  end
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
  .NLINES(NLINES), .TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .bus_issue(bus_issue), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid),
  .snp_addr(snp_addr), .snp_id(snp_id), .flush_valid(flush_valid), .st(st)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;
  localparam int IDX_W = 3, TAG_W = 4, ID_W = 2, AW = 7;
  localparam logic [1:0] I = 2'b00, S = 2'b01, M = 2'b10;
  localparam logic [1:0] NONE = 2'b00, RD = 2'b01, RDX = 2'b10, WB = 2'b11;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic [ID_W-1:0] snp_id = '0;
  logic [IDX_W-1:0] look_idx = '0;
  logic cpu_done, bus_req, bus_issue, flush_valid;
  logic [1:0] bus_cmd, look_state;
  logic [AW-1:0] bus_addr, flush_addr;
  logic [TAG_W-1:0] look_tag;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  msi_snoop_ctrl #(.NLINES(8), .TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(2'd0)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_issue(bus_issue),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_id(snp_id), .flush_valid(flush_valid), .flush_addr(flush_addr),
    .look_idx(look_idx), .look_state(look_state), .look_tag(look_tag));

  function automatic logic [AW-1:0] A(input int t, input int x);
    return {4'(t), 3'(x)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic we, input logic [AW-1:0] ad, input logic g,
                      input logic sv, input logic [1:0] sc, input logic [AW-1:0] sa,
                      input logic [ID_W-1:0] sid);
    @(negedge clk);
    cpu_req = rq; cpu_we = we; cpu_addr = ad; bus_gnt = g;
    snp_valid = sv; snp_cmd = sc; snp_addr = sa; snp_id = sid;
    #2;
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, NONE, '0, '0);
  endtask

  task automatic line(input string req, input int idx, input int es, input int et);
    idle();
    look_idx = 3'(idx);
    #1;
    chk(req, "state", look_state, es);
    if (es != I) chk(req, "tag", look_tag, et);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) line("R1", k, I, 0);
  endtask

  task automatic t_read_miss();
    step(1, 0, A(3,1), 0, 0, NONE, '0, '0);
    chk("R9", "bus_req no grant", bus_req, 1);
    chk("R9", "issue no grant", bus_issue, 0);
    chk("R9", "done no grant", cpu_done, 0);
    step(1, 0, A(3,1), 1, 0, NONE, '0, '0);
    chk("R2", "issue", bus_issue, 1);
    chk("R2", "cmd", bus_cmd, RD);
    chk("R2", "addr", bus_addr, A(3,1));
    chk("R2", "done", cpu_done, 1);
    line("R2", 1, S, 3);
  endtask

  task automatic t_local_hits();
    step(1, 0, A(3,1), 0, 0, NONE, '0, '0);
    chk("R4", "read S done", cpu_done, 1);
    chk("R4", "read S req", bus_req, 0);
    step(1, 1, A(3,1), 1, 0, NONE, '0, '0);
    chk("R3", "upgrade cmd", bus_cmd, RDX);
    chk("R3", "upgrade done", cpu_done, 1);
    line("R3", 1, M, 3);
    step(1, 1, A(3,1), 0, 0, NONE, '0, '0);
    chk("R4", "write M done", cpu_done, 1);
    chk("R4", "write M req", bus_req, 0);
    step(1, 0, A(3,1), 0, 0, NONE, '0, '0);
    chk("R4", "read M done", cpu_done, 1);
    line("R4", 1, M, 3);
  endtask

  task automatic t_snoop_rd_mod();
    step(0, 0, '0, 0, 1, RD, A(3,1), 2'd1);
    chk("R5", "flush", flush_valid, 1);
    chk("R5", "flush addr", flush_addr, A(3,1));
    line("R5", 1, S, 3);
  endtask

  task automatic t_snoop_silent();
    step(0, 0, '0, 0, 1, RD, A(3,1), 2'd2);
    chk("R7", "rd on S flush", flush_valid, 0);
    step(0, 0, '0, 0, 1, WB, A(3,1), 2'd2);
    chk("R7", "wb flush", flush_valid, 0);
    step(0, 0, '0, 0, 1, RDX, A(4,1), 2'd2);
    chk("R7", "tag miss flush", flush_valid, 0);
    line("R7", 1, S, 3);
  endtask

  task automatic t_snoop_rdx();
    step(0, 0, '0, 0, 1, RDX, A(3,1), 2'd3);
    chk("R6", "S flush", flush_valid, 0);
    line("R6", 1, I, 0);
    step(1, 1, A(5,2), 1, 0, NONE, '0, '0);
    chk("R3", "miss cmd", bus_cmd, RDX);
    chk("R3", "miss addr", bus_addr, A(5,2));
    chk("R3", "miss done", cpu_done, 1);
    line("R3", 2, M, 5);
    step(0, 0, '0, 0, 1, RDX, A(5,2), 2'd1);
    chk("R6", "M flush", flush_valid, 1);
    line("R6", 2, I, 0);
  endtask

  task automatic t_own_id();
    step(1, 1, A(6,3), 1, 0, NONE, '0, '0);
    chk("R3", "done", cpu_done, 1);
    step(0, 0, '0, 0, 1, RDX, A(6,3), 2'd0);
    chk("R8", "own flush", flush_valid, 0);
    line("R8", 3, M, 6);
  endtask

  task automatic t_replace();
    step(1, 0, A(9,3), 1, 0, NONE, '0, '0);
    chk("R10", "wb cmd", bus_cmd, WB);
    chk("R10", "wb addr", bus_addr, A(6,3));
    chk("R10", "wb issue", bus_issue, 1);
    chk("R10", "wb not done", cpu_done, 0);
    step(1, 0, A(9,3), 1, 0, NONE, '0, '0);
    chk("R10", "fetch cmd", bus_cmd, RD);
    chk("R10", "fetch addr", bus_addr, A(9,3));
    chk("R10", "fetch done", cpu_done, 1);
    line("R10", 3, S, 9);
  endtask

  task automatic t_conflict();
    step(1, 0, A(1,5), 1, 1, RD, A(2,5), 2'd1);
    chk("R11", "req under snoop", bus_req, 0);
    chk("R11", "issue under snoop", bus_issue, 0);
    chk("R11", "done under snoop", cpu_done, 0);
    step(1, 0, A(1,5), 1, 0, NONE, '0, '0);
    chk("R11", "done after snoop", cpu_done, 1);
    step(1, 1, A(1,5), 1, 0, NONE, '0, '0);
    chk("R3", "to M", cpu_done, 1);
    step(1, 1, A(1,5), 0, 1, RDX, A(1,5), 2'd2);
    chk("R11", "hit stalled", cpu_done, 0);
    chk("R11", "snoop flush", flush_valid, 1);
    step(1, 1, A(1,5), 1, 0, NONE, '0, '0);
    chk("R11", "refetch cmd", bus_cmd, RDX);
    chk("R11", "refetch done", cpu_done, 1);
    line("R11", 5, M, 1);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_read_miss();
    t_local_hits();
    t_snoop_rd_mod();
    t_local_hits_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic t_local_hits_again();
    t_snoop_silent();
    t_snoop_rdx();
    t_own_id();
    t_replace();
    t_conflict();
  endtask
endmodule